// File: doc/BRIEF.md
# Coprocessor Register Transfer Handshake Controller

This block sits on the coprocessor side of a host core's pipeline and takes part in single-register move instructions in both directions: moves from the core into a coprocessor register, and moves from a coprocessor register back to the core. It watches the core's instruction word together with an active-low request strobe. It follows each accepted instruction through the decode, execute, memory and write stages, and answers on two 2-bit handshake buses. The decode bus carries the first response. The execute bus carries any further busy-wait cycles and the final LAST beat.

An instruction is claimed only when its coprocessor-number field matches the number the block is built with. The number of busy-wait beats comes from a runtime input. For an inbound move the block stores the core's data into a 16-entry local register file, but only if the transfer is not cancelled after LAST. For an outbound move it presents the selected register on the read-data bus during the memory stage. The block tracks one transfer at a time: a request strobe is only taken as a new decode while the block is idle.

Top module: `cpx_xfer_unit`

## Requirements
- R1: After synchronous reset, both handshake buses read ABSENT (2'b00), the read-data bus reads zero and every local register holds zero.
- R2: In the cycle after a decode strobe (req_n low while idle) with a matching coprocessor number in instruction bits 11:8, the decode bus shows LAST (2'b11) if the captured wait count is zero, or WAIT (2'b01) otherwise. In every other cycle it shows ABSENT. GO (2'b10) is never driven.
- R3: An instruction whose bits 11:8 differ from the configured number gets no response: both buses stay ABSENT and no register changes.
- R4: With a wait count N from 1 to 15, the execute bus shows WAIT for N-1 cycles after the first execute cycle and then LAST for one cycle. Counting the decode bus, exactly N WAIT beats precede LAST, and both buses are ABSENT in the cycle after LAST.
- R5: If, in the first execute cycle, req_n is high or the condition-pass input is low, the transfer is abandoned. The execute bus stays ABSENT and no register or read data changes.
- R6: Bit 20 low selects a core-to-coprocessor move into the register named by bits 19:16. The write data present in the write stage (two cycles after LAST) is stored there.
- R7: Bit 20 high selects a coprocessor-to-core move. The read-data bus carries the named register's value in the cycle after LAST (the memory stage) and reads zero in all other cycles.
- R8: A core-to-coprocessor move is dropped, with no register changed, if condition-pass is low or late-cancel is high in the cycle after LAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low request strobe (decode, then issue) |
| instr | input | 32 | Instruction word from the core |
| cond_pass | input | 1 | Condition-pass indication from the core |
| late_cancel | input | 1 | Late cancel from the core |
| wait_cycles | input | 4 | Busy-wait beats to insert before LAST |
| wr_data | input | 32 | Core-to-coprocessor data, valid in the write stage |
| dec_hs | output | 2 | Decode handshake response |
| exe_hs | output | 2 | Execute handshake response |
| rd_data | output | 32 | Coprocessor-to-core data, valid in the memory stage |

## Verification
Every output is registered. The decode response therefore appears one cycle after the decode strobe, and each execute beat one cycle after the previous beat. Read data appears in the cycle after LAST, and a stored write becomes visible only through a later outbound move. The bench drives inputs on the falling edge and compares all three outputs with a behavioural model in every cycle of every transfer. Each check is placed in the cycle in which that stage is due, counting from the decode strobe plus the requested wait count. Ignored transfers (no match, no issue, failed condition, late cancel) are confirmed by reading the register back through a normal outbound move.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    localparam int INSTR_W   = 32;
    localparam int DIR_POS   = 20;
    localparam int IDX_LO    = 16;
    localparam int IDX_W_FLD = 4;
    localparam int CPN_LO    = 8;
    localparam int CPN_W     = 4;

    typedef enum logic [1:0] {
        HS_ABSENT = 2'b00,
        HS_WAIT   = 2'b01,
        HS_GO     = 2'b10,
        HS_LAST   = 2'b11
    } hs_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_EXE1,
        PH_STALL,
        PH_MEM,
        PH_WB
    } phase_t;

    typedef struct packed {
        logic                 to_core;
        logic [IDX_W_FLD-1:0] reg_idx;
        logic [CPN_W-1:0]     cp_num;
    } xfer_fields_t;

    typedef struct packed {
        logic                 to_core;
        logic [IDX_W_FLD-1:0] reg_idx;
    } xfer_ctl_t;

    function automatic xfer_fields_t split_instr(input logic [INSTR_W-1:0] w);
        xfer_fields_t f;
        f.to_core = w[DIR_POS];
        f.reg_idx = w[IDX_LO +: IDX_W_FLD];
        f.cp_num  = w[CPN_LO +: CPN_W];
        return f;
    endfunction

    function automatic hs_t beat_code(input logic remaining_zero);
        return remaining_zero ? HS_LAST : HS_WAIT;
    endfunction

endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
    import cpx_pkg::*;
#(
    parameter logic [CPN_W-1:0] CP_ID = 4'd7
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               req_n,
    output logic               claim,
    output xfer_ctl_t          ctl
);
    xfer_fields_t fld;
    logic         unused_bits;

    assign fld         = split_instr(instr);
    assign unused_bits = ^{instr[INSTR_W-1:DIR_POS+1], instr[IDX_LO-1:CPN_LO+CPN_W],
                           instr[CPN_LO-1:0]};

    always_comb begin
        claim       = !req_n && (fld.cp_num == CP_ID);
        ctl.to_core = fld.to_core;
        ctl.reg_idx = fld.reg_idx;
    end
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
    import cpx_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              claim,
    input  xfer_ctl_t         ctl_in,
    input  logic              req_n,
    input  logic              cond_pass,
    input  logic              late_cancel,
    input  logic [WAIT_W-1:0] wait_cycles,
    output hs_t               dec_hs,
    output hs_t               exe_hs,
    output logic              rd_load,
    output logic              rd_clr,
    output logic              wr_en,
    output logic [IDX_W_FLD-1:0] reg_idx
);
    phase_t            phase_q, phase_d;
    xfer_ctl_t         ctl_q;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic              left_zero;
    logic              issue_ok;
    logic              last_now;
    logic              keep_write;

    assign left_zero  = (wait_q == '0);
    assign issue_ok   = !req_n && cond_pass;
    assign keep_write = cond_pass && !late_cancel && !ctl_q.to_core;

    always_comb begin
        last_now = 1'b0;
        case (phase_q)
            PH_EXE1:  last_now = issue_ok && left_zero;
            PH_STALL: last_now = left_zero;
            default:  last_now = 1'b0;
        endcase
    end

    always_comb begin
        phase_d = phase_q;
        wait_d  = wait_q;
        case (phase_q)
            PH_IDLE: begin
                if (claim) begin
                    phase_d = PH_EXE1;
                    wait_d  = wait_cycles;
                end
            end
            PH_EXE1: begin
                if (!issue_ok) begin
                    phase_d = PH_IDLE;
                end else if (left_zero) begin
                    phase_d = PH_MEM;
                end else begin
                    phase_d = PH_STALL;
                    wait_d  = wait_q - WAIT_W'(1);
                end
            end
            PH_STALL: begin
                if (left_zero) begin
                    phase_d = PH_MEM;
                end else begin
                    wait_d = wait_q - WAIT_W'(1);
                end
            end
            PH_MEM:  phase_d = keep_write ? PH_WB : PH_IDLE;
            PH_WB:   phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            wait_q  <= '0;
            ctl_q   <= '0;
        end else begin
            phase_q <= phase_d;
            wait_q  <= wait_d;
            if (phase_q == PH_IDLE && claim) begin
                ctl_q <= ctl_in;
            end
        end
    end

    always_comb begin
        dec_hs = (phase_q == PH_EXE1)  ? beat_code(left_zero) : HS_ABSENT;
        exe_hs = (phase_q == PH_STALL) ? beat_code(left_zero) : HS_ABSENT;
    end

    assign rd_load = last_now && ctl_q.to_core;
    assign rd_clr  = (phase_q == PH_MEM);
    assign wr_en   = (phase_q == PH_WB);
    assign reg_idx = ctl_q.reg_idx;
endmodule

// File: rtl/cpx_regfile.sv
module cpx_regfile #(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 16,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_load,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [REG_CNT];

    for (genvar g = 0; g < REG_CNT; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                cells[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_load) begin
            rd_data <= cells[idx];
        end else if (rd_clr) begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/cpx_xfer_unit.sv
module cpx_xfer_unit
    import cpx_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                REG_CNT = 16,
    parameter int                WAIT_W  = 4,
    parameter logic [CPN_W-1:0]  CP_ID   = 4'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_n,
    input  logic [31:0]       instr,
    input  logic              cond_pass,
    input  logic              late_cancel,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        dec_hs,
    output logic [1:0]        exe_hs,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(REG_CNT);

    logic                 claim;
    xfer_ctl_t            ctl;
    hs_t                  dec_hs_e, exe_hs_e;
    logic                 rd_load, rd_clr, wr_en;
    logic [IDX_W_FLD-1:0] reg_idx;

    cpx_decode #(.CP_ID(CP_ID)) u_dec (
        .instr (instr),
        .req_n (req_n),
        .claim (claim),
        .ctl   (ctl)
    );

    cpx_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .claim       (claim),
        .ctl_in      (ctl),
        .req_n       (req_n),
        .cond_pass   (cond_pass),
        .late_cancel (late_cancel),
        .wait_cycles (wait_cycles),
        .dec_hs      (dec_hs_e),
        .exe_hs      (exe_hs_e),
        .rd_load     (rd_load),
        .rd_clr      (rd_clr),
        .wr_en       (wr_en),
        .reg_idx     (reg_idx)
    );

    cpx_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .idx     (reg_idx[IDX_W-1:0]),
        .wr_data (wr_data),
        .rd_load (rd_load),
        .rd_clr  (rd_clr),
        .rd_data (rd_data)
    );

    assign dec_hs = dec_hs_e;
    assign exe_hs = exe_hs_e;
endmodule

// File: rtl/cpx_xfer_checks.sv
module cpx_xfer_checks #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        dec_hs,
    input logic [1:0]        exe_hs,
    input logic [DATA_W-1:0] rd_data
);
    localparam logic [1:0] C_ABSENT = 2'b00;
    localparam logic [1:0] C_WAIT   = 2'b01;
    localparam logic [1:0] C_LAST   = 2'b11;

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dec_hs == C_ABSENT && exe_hs == C_ABSENT && rd_data == '0));

    a_r2_dec_single_beat: assert property (@(posedge clk) disable iff (rst)
        (dec_hs != C_ABSENT) |=> (dec_hs == C_ABSENT));

    a_r2_buses_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dec_hs != C_ABSENT && exe_hs != C_ABSENT));

    a_r4_wait_continues: assert property (@(posedge clk) disable iff (rst)
        (exe_hs == C_WAIT) |=> (exe_hs == C_WAIT || exe_hs == C_LAST));

    a_r4_quiet_after_last: assert property (@(posedge clk) disable iff (rst)
        (exe_hs == C_LAST) |=> (exe_hs == C_ABSENT && dec_hs == C_ABSENT));

    a_r7_read_follows_last: assert property (@(posedge clk) disable iff (rst)
        (rd_data != '0) |-> $past(dec_hs == C_LAST || exe_hs == C_LAST));
endmodule

bind cpx_xfer_unit cpx_xfer_checks #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .dec_hs  (dec_hs),
    .exe_hs  (exe_hs),
    .rd_data (rd_data)
);

// File: tb/cpx_xfer_unit_test.sv
`timescale 1ns/1ps
module cpx_xfer_unit_test;
    localparam logic [3:0] MY_CP = 4'd7;
    localparam logic [1:0] ABS = 2'b00, WT = 2'b01, LST = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_n = 1'b1;
    logic [31:0] instr = '0;
    logic        cond_pass = 1'b0;
    logic        late_cancel = 1'b0;
    logic [3:0]  wait_cycles = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  dec_hs, exe_hs;
    logic [31:0] rd_data;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] model [16];

    always #5 clk = ~clk;

    cpx_xfer_unit uut (
        .clk(clk), .rst(rst), .req_n(req_n), .instr(instr),
        .cond_pass(cond_pass), .late_cancel(late_cancel),
        .wait_cycles(wait_cycles), .wr_data(wr_data),
        .dec_hs(dec_hs), .exe_hs(exe_hs), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            total++; fails++;
            $display("FAIL watchdog (all reqs): actual cycles=%0d expected < 50000", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic logic [31:0] mk_instr(input bit to_core, input int idx, input int cpn);
        return {11'h70E, to_core, 4'(idx), 4'h1, 4'(cpn), 8'h10};
    endfunction

    // One clock: drive at the falling edge, then compare the registered outputs
    task automatic cyc(input logic rq, input logic [31:0] ins, input logic cp,
                       input logic lc, input logic [31:0] wd,
                       input logic [1:0] e_dec, input logic [1:0] e_exe,
                       input logic [31:0] e_rd, input string tag);
        @(negedge clk);
        req_n = rq; instr = ins; cond_pass = cp; late_cancel = lc; wr_data = wd;
        #1;
        total++;
        if (dec_hs !== e_dec || exe_hs !== e_exe || rd_data !== e_rd) begin
            fails++;
            $display("FAIL %s: actual dec=%b exe=%b rd=%h expected dec=%b exe=%b rd=%h",
                     tag, dec_hs, exe_hs, rd_data, e_dec, e_exe, e_rd);
        end
    endtask

    task automatic xfer(input bit to_core, input int idx, input int cpn, input int waits,
                        input bit issue, input bit cp_e1, input bit cp_m, input bit lc_m,
                        input logic [31:0] wd, input string tag);
        logic [31:0] ins;
        bit hit;
        ins = mk_instr(to_core, idx, cpn);
        hit = (cpn == int'(MY_CP));
        wait_cycles = 4'(waits);
        // decode cycle: block idle
        cyc(1'b0, ins, 1'b0, 1'b0, '0, ABS, ABS, '0, tag);
        // first execute cycle: decode response due (R2)
        cyc(issue ? 1'b0 : 1'b1, ins, cp_e1, 1'b0, '0,
            hit ? ((waits == 0) ? LST : WT) : ABS, ABS, '0, tag);
        if (hit && issue && cp_e1) begin
            for (int k = 1; k <= waits; k++) begin
                cyc(1'b1, '0, 1'b0, 1'b0, '0, ABS, (k == waits) ? LST : WT, '0, tag);
            end
            // memory stage: read data due (R7)
            cyc(1'b1, '0, cp_m, lc_m, '0, ABS, ABS, to_core ? model[idx] : '0, tag);
            if (!to_core && cp_m && !lc_m) begin
                // write stage: data captured (R6)
                cyc(1'b1, '0, 1'b0, 1'b0, wd, ABS, ABS, '0, tag);
                model[idx] = wd;
            end
        end
        cyc(1'b1, '0, 1'b0, 1'b0, '0, ABS, ABS, '0, tag);
    endtask

    task automatic rd(input int idx, input int waits, input string tag);
        xfer(1'b1, idx, int'(MY_CP), waits, 1'b1, 1'b1, 1'b1, 1'b0, '0, tag);
    endtask

    task automatic wr(input int idx, input int waits, input logic [31:0] v, input string tag);
        xfer(1'b0, idx, int'(MY_CP), waits, 1'b1, 1'b1, 1'b1, 1'b0, v, tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle outputs and cleared registers
        cyc(1'b1, '0, 1'b0, 1'b0, '0, ABS, ABS, '0, "R1");
        rd(3, 0, "R1");
        rd(12, 2, "R1");
        // R6/R7/R2 zero-wait write and read
        wr(3, 0, 32'hA5A5_1234, "R6");
        rd(3, 0, "R7");
        // R4 stalled transfers
        rd(3, 2, "R4");
        wr(15, 15, 32'hDEAD_0F0F, "R4");
        rd(15, 1, "R4");
        rd(15, 15, "R4");
        // R3 foreign coprocessor number
        xfer(1'b0, 3, 5, 0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h1111_1111, "R3");
        xfer(1'b1, 3, 8, 3, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R3");
        rd(3, 0, "R3");
        // R5 condition fails or no issue strobe in first execute cycle
        xfer(1'b0, 3, int'(MY_CP), 0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h2222_2222, "R5");
        xfer(1'b0, 3, int'(MY_CP), 4, 1'b0, 1'b1, 1'b1, 1'b0, 32'h3333_3333, "R5");
        xfer(1'b1, 15, int'(MY_CP), 2, 1'b1, 1'b0, 1'b1, 1'b0, '0, "R5");
        rd(3, 0, "R5");
        // R8 cancellation after LAST
        xfer(1'b0, 3, int'(MY_CP), 0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h4444_4444, "R8");
        xfer(1'b0, 3, int'(MY_CP), 3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h5555_5555, "R8");
        rd(3, 1, "R8");
        // every register, mixed wait counts (R6, R7)
        for (int i = 0; i < 16; i++) wr(i, i % 4, 32'h0101_0101 * (i + 1) ^ 32'h8000_00F0, "R6");
        for (int i = 15; i >= 0; i--) rd(i, (i * 3) % 16, "R7");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule